// File: doc/BRIEF.md
# Clock Frequency Change Sequencer

This block steps a system through a clock frequency change. Software picks a target rate by writing a one-hot code into a control register. A 0-to-1 transition of exactly one valid code bit starts a timed sequence, provided the sequencer is idle. The block first asserts an active-low freeze request and waits for the system to return a freeze acknowledge. It then drives three active-low clock-change strobes, then a PLL bypass output. After a fixed hold it releases the strobes and the bypass together. Once a settle interval has passed, it releases the freeze.

Each gap in the sequence comes from its own programmable delay register, counted in block clocks. The assert-change delay is 8 bits, the assert-bypass delay is 16 bits and the PLL-settle delay is 32 bits. A 32-bit switch-latency value is held for software but does not time any step. Software normally clears the control register a few clocks after setting it, and clearing never starts a sequence. A read-only status word reports whether the sequencer is busy.

Top module: `freq_step_sequencer`

## Requirements
- R1: After reset, `clkChangeN` is 3'b111, `pllBypass` is 0, `freezeN` is 1 and `busy` is 0. The delay registers read their maximum values: assert-change 0xFF at address 1, assert-bypass 0xFFFF at address 2, settle 0xFFFFFFFF at address 3 and switch latency 0xFFFFFFFF at address 4.
- R2: The control register is at address 0. It keeps only bit 0 (full rate, 0x01), bit 1 (half rate, 0x02) and bit 5 (one thirty-second rate, 0x20). Every other bit reads back as 0.
- R3: A control write in which at least one of the three valid bits goes from 0 to 1, and which leaves exactly one valid bit set, starts a sequence while the block is idle. Reserved bits in the written value do not matter. In the cycle after that write edge, `busy` is 1 and `freezeN` is 0.
- R4: A control write starts nothing when any of the following holds: it sets more than one valid bit; it has no rising valid bit (a clear, or a rewrite of the same value); it sets only reserved bits.
- R5: While `busy` is 1, control writes update the register but never start a second sequence. Status bit 0 at address 5 reads the busy flag.
- R6: While waiting for acknowledge, the strobes stay high until `freezeAck` is sampled high at a clock edge.
- R7: The strobes go low max(A,1) clock edges after the edge at which `freezeAck` is sampled high, where A is the assert-change delay.
- R8: `pllBypass` rises max(B,1) edges after the strobes go low, where B is the assert-bypass delay. It is 1 only while the strobes are low.
- R9: The strobes and `pllBypass` are released on the same edge, max(HOLD_CYCLES,1) edges after the bypass rises.
- R10: `freezeN` returns high max(S,1) edges after the strobes are released, where S is the settle delay. `busy` falls one edge later.
- R11: A write to a delay register keeps only that register's width of data, so 0x1FF written to address 1 reads 0xFF. The switch-latency register reads back the full written word. Writes to addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 32 | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | 32 | Register read data (combinational) |
| freezeAck | input | 1 | Freeze acknowledge from the system |
| clkChangeN | output | 3 | Active-low clock-change strobes |
| pllBypass | output | 1 | PLL bypass request |
| freezeN | output | 1 | Active-low freeze request |
| busy | output | 1 | Sequence in progress |

## Verification
The hardest condition to reach is a trigger-qualifying write that lands while a sequence is already running. From the ports such a write looks exactly like a legal start, so the stimulus has to hold `freezeAck` low to park the sequencer in its acknowledge wait. While it is parked, the bench writes a clear and then a fresh single rising code. It then lets the sequence finish and watches that `busy` stays low. The table of control writes walks, from each register state in turn, the cases of a rising code, a double code, a rewrite, a clear and reserved-only bits. Directed runs then time every phase edge by edge, once with non-trivial delays and once with all delays at zero.

// File: rtl/freq_seq_pkg.sv
package freq_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_ACK,
    ST_PRE_CHG,
    ST_CHG_ON,
    ST_BYP_HOLD,
    ST_SETTLE,
    ST_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    LD_ACT,
    LD_BYP,
    LD_HOLD,
    LD_SETTLE
  } load_sel_e;

  typedef struct packed {
    logic      load;
    load_sel_e sel;
  } seq_cmd_t;

  localparam logic [7:0] CODE_FULL  = 8'h01;
  localparam logic [7:0] CODE_HALF  = 8'h02;
  localparam logic [7:0] CODE_DIV32 = 8'h20;
  localparam logic [7:0] CODE_MASK  = CODE_FULL | CODE_HALF | CODE_DIV32;

  localparam int ADR_CTRL    = 0;
  localparam int ADR_ACT     = 1;
  localparam int ADR_BYP     = 2;
  localparam int ADR_SETTLE  = 3;
  localparam int ADR_LATENCY = 4;
  localparam int ADR_STATUS  = 5;

endpackage

// File: rtl/freq_seq_datapath.sv
module freq_seq_datapath
  import freq_seq_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 3,
  parameter int ACT_W       = 8,
  parameter int BYP_W       = 16,
  parameter int SETTLE_W    = 32,
  parameter int LAT_W       = 32,
  parameter int CNT_W       = 32,
  parameter int HOLD_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              busy,
  input  seq_cmd_t          cmd,
  output logic              trig,
  output logic              cntDone
);

  localparam int CTRL_W = 8;

  logic [CTRL_W-1:0]   ctrlReg;
  logic [ACT_W-1:0]    actDly;
  logic [BYP_W-1:0]    bypDly;
  logic [SETTLE_W-1:0] settleDly;
  logic [LAT_W-1:0]    latVal;
  logic [CNT_W-1:0]    cnt;
  logic [CNT_W-1:0]    loadVal;

  logic [CTRL_W-1:0] ctrlNew;
  logic [CTRL_W-1:0] ctrlRise;
  logic              ctrlWr;
  logic              newOneHot;

  assign ctrlWr    = wrEn && (wrAddr == ADDR_W'(ADR_CTRL));
  assign ctrlNew   = wrData[CTRL_W-1:0] & CODE_MASK;
  assign ctrlRise  = ctrlNew & ~ctrlReg;
  assign newOneHot = (ctrlNew != '0) && ((ctrlNew & (ctrlNew - 1'b1)) == '0);
  assign trig      = ctrlWr && (ctrlRise != '0) && newOneHot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      actDly    <= '1;
      bypDly    <= '1;
      settleDly <= '1;
      latVal    <= '1;
    end else if (wrEn) begin
      case (int'(wrAddr))
        ADR_CTRL:    ctrlReg   <= ctrlNew;
        ADR_ACT:     actDly    <= wrData[ACT_W-1:0];
        ADR_BYP:     bypDly    <= wrData[BYP_W-1:0];
        ADR_SETTLE:  settleDly <= wrData[SETTLE_W-1:0];
        ADR_LATENCY: latVal    <= wrData[LAT_W-1:0];
        default:     ;
      endcase
    end
  end

  always_comb begin
    unique case (cmd.sel)
      LD_ACT:    loadVal = CNT_W'(actDly);
      LD_BYP:    loadVal = CNT_W'(bypDly);
      LD_HOLD:   loadVal = CNT_W'(HOLD_CYCLES);
      LD_SETTLE: loadVal = CNT_W'(settleDly);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (cmd.load)      cnt <= loadVal;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign cntDone = (cnt <= CNT_W'(1));

  always_comb begin
    rdData = '0;
    case (int'(rdAddr))
      ADR_CTRL:    rdData = DATA_W'(ctrlReg);
      ADR_ACT:     rdData = DATA_W'(actDly);
      ADR_BYP:     rdData = DATA_W'(bypDly);
      ADR_SETTLE:  rdData = DATA_W'(settleDly);
      ADR_LATENCY: rdData = DATA_W'(latVal);
      ADR_STATUS:  rdData = DATA_W'(busy);
      default:     rdData = '0;
    endcase
  end

  // R7: the phase counter steps down by exactly one while no reload occurs
  p_count_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.load && cnt > CNT_W'(1)) |=> (cnt == $past(cnt) - 1'b1));

  // R10: a drained counter stays at zero until reloaded
  p_count_floor_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.load && cnt == '0) |=> (cnt == '0));

  // R2: no reserved control bit is ever held
  p_ctrl_reserved_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg & ~CODE_MASK) == '0);

endmodule

// File: rtl/freq_seq_control.sv
module freq_seq_control
  import freq_seq_pkg::*;
#(
  parameter int STROBE_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                trig,
  input  logic                freezeAck,
  input  logic                cntDone,
  output seq_cmd_t            cmd,
  output logic                busy,
  output logic [STROBE_W-1:0] clkChangeN,
  output logic                pllBypass,
  output logic                freezeN
);

  seq_state_e state;
  seq_state_e nxt;
  logic       chgQ;
  logic       bypQ;
  logic       frzQ;

  always_comb begin
    nxt      = state;
    cmd.load = 1'b0;
    cmd.sel  = LD_ACT;
    unique case (state)
      ST_IDLE: begin
        if (trig) nxt = ST_WAIT_ACK;
      end
      ST_WAIT_ACK: begin
        if (freezeAck) begin
          nxt      = ST_PRE_CHG;
          cmd.load = 1'b1;
          cmd.sel  = LD_ACT;
        end
      end
      ST_PRE_CHG: begin
        if (cntDone) begin
          nxt      = ST_CHG_ON;
          cmd.load = 1'b1;
          cmd.sel  = LD_BYP;
        end
      end
      ST_CHG_ON: begin
        if (cntDone) begin
          nxt      = ST_BYP_HOLD;
          cmd.load = 1'b1;
          cmd.sel  = LD_HOLD;
        end
      end
      ST_BYP_HOLD: begin
        if (cntDone) begin
          nxt      = ST_SETTLE;
          cmd.load = 1'b1;
          cmd.sel  = LD_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (cntDone) nxt = ST_DONE;
      end
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      chgQ  <= 1'b0;
      bypQ  <= 1'b0;
      frzQ  <= 1'b0;
    end else begin
      state <= nxt;
      chgQ  <= (nxt == ST_CHG_ON) || (nxt == ST_BYP_HOLD);
      bypQ  <= (nxt == ST_BYP_HOLD);
      frzQ  <= (nxt != ST_IDLE) && (nxt != ST_DONE);
    end
  end

  assign busy       = (state != ST_IDLE);
  assign clkChangeN = {STROBE_W{~chgQ}};
  assign pllBypass  = bypQ;
  assign freezeN    = ~frzQ;

  // R1: an idle sequencer drives every output inactive
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (clkChangeN == '1 && !pllBypass && freezeN));

  // R3: a qualifying write in idle starts the freeze on the next edge
  p_trig_starts_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && trig) |=> (busy && !freezeN));

  // R5: busy only ever rises in response to a trigger
  p_busy_cause_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(trig));

  // R6: without acknowledge the sequencer keeps waiting
  p_ack_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_ACK && !freezeAck) |=> (state == ST_WAIT_ACK && clkChangeN == '1));

  // R8: bypass only while strobes are asserted and freeze is held
  p_bypass_inside_r8: assert property (@(posedge clk) disable iff (!rstN)
    pllBypass |-> (clkChangeN == '0 && !freezeN));

  // R9: strobes and bypass release on the same edge
  p_release_together_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkChangeN[0]) |-> $fell(pllBypass));

endmodule

// File: rtl/freq_step_sequencer.sv
module freq_step_sequencer
  import freq_seq_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 3,
  parameter int ACT_W       = 8,
  parameter int BYP_W       = 16,
  parameter int SETTLE_W    = 32,
  parameter int LAT_W       = 32,
  parameter int STROBE_W    = 3,
  parameter int HOLD_CYCLES = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [ADDR_W-1:0]   rdAddr,
  output logic [DATA_W-1:0]   rdData,
  input  logic                freezeAck,
  output logic [STROBE_W-1:0] clkChangeN,
  output logic                pllBypass,
  output logic                freezeN,
  output logic                busy
);

  localparam int W_AB  = (ACT_W > BYP_W) ? ACT_W : BYP_W;
  localparam int W_ABS = (W_AB > SETTLE_W) ? W_AB : SETTLE_W;
  localparam int CNT_W = (W_ABS > $clog2(HOLD_CYCLES + 1)) ? W_ABS : $clog2(HOLD_CYCLES + 1);

  seq_cmd_t cmd;
  logic     trig;
  logic     cntDone;

  freq_seq_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ACT_W(ACT_W), .BYP_W(BYP_W),
    .SETTLE_W(SETTLE_W), .LAT_W(LAT_W), .CNT_W(CNT_W), .HOLD_CYCLES(HOLD_CYCLES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .busy(busy), .cmd(cmd),
    .trig(trig), .cntDone(cntDone)
  );

  freq_seq_control #(
    .STROBE_W(STROBE_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .trig(trig), .freezeAck(freezeAck), .cntDone(cntDone),
    .cmd(cmd), .busy(busy), .clkChangeN(clkChangeN), .pllBypass(pllBypass),
    .freezeN(freezeN)
  );

endmodule

// File: tb/freq_step_sequencer_test.sv
module freq_step_sequencer_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        freezeAck = 1'b0;
  logic [2:0]  clkChangeN;
  logic        pllBypass;
  logic        freezeN;
  logic        busy;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  freq_step_sequencer uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .freezeAck(freezeAck),
    .clkChangeN(clkChangeN), .pllBypass(pllBypass), .freezeN(freezeN), .busy(busy)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // {expected start, control byte written}
  localparam logic [8:0] VEC [14] = '{
    {1'b1, 8'h01}, {1'b0, 8'h00}, {1'b0, 8'h03}, {1'b0, 8'h00},
    {1'b1, 8'h20}, {1'b0, 8'h20}, {1'b0, 8'h22}, {1'b0, 8'h02},
    {1'b0, 8'h00}, {1'b0, 8'hDC}, {1'b1, 8'h02}, {1'b0, 8'h21},
    {1'b0, 8'h00}, {1'b1, 8'h81}
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk);
    #1 wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rdAddr = a;
    #1 d = rdData;
  endtask

  task automatic drain();
    for (int i = 0; i < 100 && busy; i++) @(negedge clk);
  endtask

  // After a start write: samples at the negedge after edge W+k.
  task automatic measure(input int ackK, output int kChg, output int kByp,
                         output int kRel, output int kFrz, output int kIdle,
                         output bit strobeEarly);
    kChg = -1; kByp = -1; kRel = -1; kFrz = -1; kIdle = -1; strobeEarly = 0;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if (k == ackK) freezeAck = 1'b1;
      if (kChg < 0 && clkChangeN == 3'b000) kChg = k;
      if (kChg < 0 && k <= ackK && clkChangeN != 3'b111) strobeEarly = 1;
      if (kByp < 0 && pllBypass) kByp = k;
      if (kChg >= 0 && kRel < 0 && clkChangeN == 3'b111 && !pllBypass) kRel = k;
      if (kRel >= 0 && kFrz < 0 && freezeN) kFrz = k;
      if (kFrz >= 0 && kIdle < 0 && !busy) begin
        kIdle = k;
        break;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int kc, kb, kr, kf, ki;
    bit early;

    // R1: reset state
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(clkChangeN == 3'b111 && !pllBypass && freezeN && !busy, "R1 outputs",
          {clkChangeN, pllBypass, freezeN, busy}, 6'b111010);
    rd(1, v); check(v == 32'hFF, "R1 act max", v, 32'hFF);
    rd(2, v); check(v == 32'hFFFF, "R1 byp max", v, 32'hFFFF);
    rd(3, v); check(v == 32'hFFFFFFFF, "R1 settle max", v, 32'hFFFFFFFF);
    rd(4, v); check(v == 32'hFFFFFFFF, "R1 latency max", v, 32'hFFFFFFFF);

    // R11: width truncation and read-back
    wr(1, 32'h1FF); rd(1, v); check(v == 32'hFF, "R11 act trunc", v, 32'hFF);
    wr(2, 32'h12345); rd(2, v); check(v == 32'h2345, "R11 byp trunc", v, 32'h2345);
    wr(4, 32'h1234_5678); rd(4, v); check(v == 32'h1234_5678, "R11 latency", v, 32'h1234_5678);
    wr(5, 32'hFFFF_FFFF); rd(1, v); check(v == 32'hFF, "R11 addr5 no effect", v, 32'hFF);
    rd(5, v); check(v == 32'h0, "R11 status unchanged", v, 0);

    // table: trigger qualification, R2 R3 R4
    wr(1, 1); wr(2, 1); wr(3, 1);
    freezeAck = 1'b1;
    for (int i = 0; i < 14; i++) begin
      wr(0, {24'h0, VEC[i][7:0]});
      @(negedge clk);
      check(busy == VEC[i][8], VEC[i][8] ? "R3 start" : "R4 no start", busy, VEC[i][8]);
      if (VEC[i][8]) check(!freezeN, "R3 freeze", freezeN, 0);
      rdAddr = 3'd0;
      #1 check(rdData == {24'h0, VEC[i][7:0] & 8'h23}, "R2 ctrl readback", rdData,
               VEC[i][7:0] & 8'h23);
      drain();
    end
    wr(0, 0);

    // R6 R7 R8 R9 R10: timed run with act=3 byp=5 settle=6, ack late
    freezeAck = 1'b0;
    wr(1, 3); wr(2, 5); wr(3, 6);
    wr(0, 32'h01);
    measure(3, kc, kb, kr, kf, ki, early);
    check(!early, "R6 strobes held before ack", early, 0);
    check(kc == 7, "R7 change delay", kc, 7);
    check(kb == 12, "R8 bypass delay", kb, 12);
    check(kr == 16, "R9 joint release", kr, 16);
    check(kf == 22, "R10 freeze release", kf, 22);
    check(ki == 23, "R10 busy drop", ki, 23);

    // zero delays, ack already high: minimum one edge per phase
    wr(0, 0);
    wr(1, 0); wr(2, 0); wr(3, 0);
    freezeAck = 1'b1;
    wr(0, 32'h20);
    measure(-1, kc, kb, kr, kf, ki, early);
    check(kc == 2, "R7 zero delay", kc, 2);
    check(kb == 3, "R8 zero delay", kb, 3);
    check(kr == 7, "R9 hold", kr, 7);
    check(kf == 8, "R10 zero settle", kf, 8);
    check(ki == 9, "R10 zero busy", ki, 9);

    // R5: writes while parked in the acknowledge wait
    wr(0, 0);
    wr(1, 2); wr(2, 2); wr(3, 2);
    freezeAck = 1'b0;
    wr(0, 32'h01);
    @(negedge clk);
    rdAddr = 3'd5;
    #1 check(rdData == 32'h1, "R5 status busy", rdData, 1);
    wr(0, 32'h00);
    wr(0, 32'h02);
    freezeAck = 1'b1;
    drain();
    check(!busy, "R5 first run ended", busy, 0);
    begin
      bit again = 0;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (busy || !freezeN) again = 1;
      end
      check(!again, "R5 no second sequence", again, 0);
    end
    rd(0, v); check(v == 32'h02, "R5 register still updated", v, 2);

    // R4: clearing after a run starts nothing
    wr(0, 0);
    @(negedge clk);
    check(!busy, "R4 clear idle", busy, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule